// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the four control strobes of a multiplexed external memory bus: an address-latch strobe, an active-low code-read strobe, and active-low data read and data write strobes. It runs from the oscillator clock. A tick counter divides the clock into machine cycles of twelve oscillator periods. The counter splits each cycle into six states of two periods, and every strobe edge sits on a fixed tick of that cycle.

Once per machine cycle, the surrounding core says what the next cycle does: an internal cycle, an external code fetch, an external data read, or an external data write. The block latches that choice on the last oscillator period of the current cycle and holds it for the whole of the next cycle. A software disable bit for the address-latch strobe can silence it. While silenced, a pull-up select output goes high so that the pad is only weakly held high. A fixed set of operating conditions overrides the disable bit.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, and `ale_pullup` is 0.
- R2: Ticks are numbered 0 to 11 inside a machine cycle. After reset is released, the first rising clock edge shows tick 0, and every output is registered so that it shows the value for the current tick. Unless R3 or R7 applies, `ale` is 1 on ticks 0, 1, 6 and 7 and is 0 on all other ticks, so it pulses at one sixth of the clock rate with a high time of two periods.
- R3: In a cycle whose kind is data read (`cyc_kind` = 2) or data write (`cyc_kind` = 3), the second `ale` pulse (ticks 6 and 7) is omitted, and the first pulse is kept.
- R4: In a cycle whose kind is code fetch (`cyc_kind` = 1), `psen_n` is 0 on ticks 2 to 4 and on ticks 8 to 10, giving two strobes per cycle. In an internal cycle (`cyc_kind` = 0), `psen_n` stays 1.
- R5: In a data read or data write cycle, both `psen_n` strobes are omitted, and `psen_n` stays 1 for the whole cycle.
- R6: `rd_n` is 0 on ticks 3 to 8 (six periods) of a data read cycle only. `wr_n` is 0 on the same ticks of a data write cycle only. The two are never 0 together.
- R7: When `ale_off` is 1 and none of `table_op`, `idle`, `pdown`, `emul` or `ext_exec` is 1, `ale` stays 0 and `ale_pullup` is 1. Otherwise `ale_pullup` is 0.
- R8: When any one of `table_op`, `idle`, `pdown` or `emul` is 1, `ale_off` is suspended: `ale` follows R2 and R3, and `ale_pullup` is 0.
- R9: When `ext_exec` is 1, `ale_off` has no effect: `ale` follows R2 and R3, and `ale_pullup` is 0.
- R10: `cyc_kind` is sampled only at the clock edge that starts tick 0. Changes to it at any other edge do not affect `psen_n`, `rd_n`, `wr_n` or `ale` in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_kind | input | 2 | Kind of the next machine cycle: 0 internal, 1 code fetch, 2 data read, 3 data write |
| ale_off | input | 1 | Software disable bit for the address-latch strobe |
| table_op | input | 1 | A data-move or code-table-read instruction is executing |
| idle | input | 1 | Idle mode is active |
| pdown | input | 1 | Power-down mode is active |
| emul | input | 1 | Emulation mode is active |
| ext_exec | input | 1 | The core is executing from external program memory |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ale_pullup | output | 1 | Selects the weak pull-up on the address-latch pad |

## Verification
Directed runs of each of the four cycle kinds show the skipped address-latch pulse and the missing code strobes in data cycles. They also show which of the read or write strobes each data kind asserts. The disable bit is then applied on its own, then with each suspending condition in turn, and then with external execution. This shows that exactly those conditions restore the strobe and release the pull-up. A further run toggles the cycle kind on every clock edge, which shows that only the value present at the start-of-cycle edge takes effect. A long random run then mixes all the inputs.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus strobe generator.
// Assumes a cycle kind is a 2-bit code supplied once per machine cycle.
package xbus_pkg;
    typedef enum logic [1:0] {
        CYC_INT   = 2'd0,
        CYC_FETCH = 2'd1,
        CYC_RD    = 2'd2,
        CYC_WR    = 2'd3
    } cyc_kind_t;
endpackage

// File: rtl/xbus_tick_ctr.sv
// Tick counter: counts oscillator periods within a machine cycle.
// Assumes reset parks the count on the last tick so that the first edge after reset is tick 0.
module xbus_tick_ctr #(
    parameter int TICKS = 12,
    localparam int TW = $clog2(TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] tick_nxt,
    output logic          cyc_start
);
    localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

    logic [TW-1:0] tick_q;

    // next tick value, wrapping at the end of the machine cycle
    always_comb begin
        cyc_start = (tick_q == LAST);
        tick_nxt  = cyc_start ? '0 : tick_q + 1'b1;
    end

    // tick register
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= LAST;
        else        tick_q <= tick_nxt;
    end
endmodule

// File: rtl/xbus_ale_gate.sv
// Address-latch disable gate: decides if the software disable is in force.
// Assumes all mode inputs are synchronous to the oscillator clock.
module xbus_ale_gate (
    input  logic ale_off,
    input  logic table_op,
    input  logic idle,
    input  logic pdown,
    input  logic emul,
    input  logic ext_exec,
    output logic gate_off
);
    logic suspend;

    // the disable is in force only with no suspending or overriding condition
    always_comb begin
        suspend  = table_op | idle | pdown | emul;
        gate_off = ale_off & ~suspend & ~ext_exec;
    end
endmodule

// File: rtl/xbus_strobe_decode.sv
// Strobe decode: maps a tick number and cycle kind to the strobe levels.
// Assumes the cycle splits into two equal halves, each carrying one latch pulse and one code strobe.
module xbus_strobe_decode
    import xbus_pkg::*;
#(
    parameter int TICKS_PER_STATE = 2,
    parameter int STATES = 6,
    localparam int TICKS = TICKS_PER_STATE * STATES,
    localparam int TW = $clog2(TICKS)
) (
    input  logic [TW-1:0] tick,
    input  cyc_kind_t     kind,
    input  logic          gate_off,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n
);
    localparam logic [TW-1:0] HALF     = TW'(TICKS / 2);
    localparam logic [TW-1:0] ALE_END  = TW'(TICKS_PER_STATE);
    localparam logic [TW-1:0] PS_BEG   = TW'(TICKS_PER_STATE);
    localparam logic [TW-1:0] PS_END   = TW'(TICKS_PER_STATE + 3);
    localparam logic [TW-1:0] DS_BEG   = TW'(TICKS_PER_STATE + 1);
    localparam logic [TW-1:0] DS_END   = TW'(TICKS_PER_STATE + 1 + TICKS / 2);

    logic [TW-1:0] hpos;
    logic          second;
    logic          data_cyc;
    logic          ds_win;

    // position inside the current half cycle
    always_comb begin
        second = (tick >= HALF);
        hpos   = second ? tick - HALF : tick;
    end

    // strobe levels for this tick
    always_comb begin
        data_cyc = (kind == CYC_RD) || (kind == CYC_WR);
        ds_win   = (tick >= DS_BEG) && (tick < DS_END);
        ale      = (hpos < ALE_END) && !(second && data_cyc) && !gate_off;
        psen_n   = !((kind == CYC_FETCH) && (hpos >= PS_BEG) && (hpos < PS_END));
        rd_n     = !((kind == CYC_RD) && ds_win);
        wr_n     = !((kind == CYC_WR) && ds_win);
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
// External bus strobe generator top: counts ticks, latches the cycle kind,
// gates the address-latch strobe and registers all strobes glitch-free.
// Assumes cyc_kind is valid on the edge that starts tick 0.
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int TICKS_PER_STATE = 2,
    parameter int STATES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cyc_kind,
    input  logic       ale_off,
    input  logic       table_op,
    input  logic       idle,
    input  logic       pdown,
    input  logic       emul,
    input  logic       ext_exec,
    output logic       ale,
    output logic       psen_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       ale_pullup
);
    localparam int TICKS = TICKS_PER_STATE * STATES;
    localparam int TW = $clog2(TICKS);

    logic [TW-1:0] tick_nxt;
    logic          cyc_start;
    cyc_kind_t     kind_q;
    cyc_kind_t     kind_nxt;
    logic          gate_off;
    logic          ale_d;
    logic          psen_d;
    logic          rd_d;
    logic          wr_d;

    xbus_tick_ctr #(.TICKS(TICKS)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_nxt  (tick_nxt),
        .cyc_start (cyc_start)
    );

    xbus_ale_gate gate_i (
        .ale_off  (ale_off),
        .table_op (table_op),
        .idle     (idle),
        .pdown    (pdown),
        .emul     (emul),
        .ext_exec (ext_exec),
        .gate_off (gate_off)
    );

    // kind for the coming tick: a new one only when a cycle begins
    always_comb begin
        kind_nxt = cyc_start ? cyc_kind_t'(cyc_kind) : kind_q;
    end

    // cycle kind register
    always_ff @(posedge clk) begin
        if (!rst_n) kind_q <= CYC_INT;
        else        kind_q <= kind_nxt;
    end

    xbus_strobe_decode #(
        .TICKS_PER_STATE (TICKS_PER_STATE),
        .STATES          (STATES)
    ) dec_i (
        .tick     (tick_nxt),
        .kind     (kind_nxt),
        .gate_off (gate_off),
        .ale      (ale_d),
        .psen_n   (psen_d),
        .rd_n     (rd_d),
        .wr_n     (wr_d)
    );

    // output registers, idle levels in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale        <= 1'b0;
            psen_n     <= 1'b1;
            rd_n       <= 1'b1;
            wr_n       <= 1'b1;
            ale_pullup <= 1'b0;
        end else begin
            ale        <= ale_d;
            psen_n     <= psen_d;
            rd_n       <= rd_d;
            wr_n       <= wr_d;
            ale_pullup <= gate_off;
        end
    end
endmodule

// File: rtl/xbus_strobe_chk.sv
// Checker for the strobe generator: protocol properties on the outputs.
// Assumes it is bound to xbus_strobe_gen and sees its ports only.
module xbus_strobe_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic ale_pullup
);
    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5
    psen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> psen_n);

    // R2
    ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && $past(ale)) |=> !ale);

    // R7
    pullup_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_pullup |-> !ale);

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |=> !rd_n);

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |=> !wr_n);
endmodule

bind xbus_strobe_gen xbus_strobe_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ale        (ale),
    .psen_n     (psen_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .ale_pullup (ale_pullup)
);

// File: tb/xbus_strobe_gen_tb_top.sv
module xbus_strobe_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cyc_kind = 2'd0;
    logic       ale_off = 1'b0;
    logic       table_op = 1'b0;
    logic       idle = 1'b0;
    logic       pdown = 1'b0;
    logic       emul = 1'b0;
    logic       ext_exec = 1'b0;
    logic       ale, psen_n, rd_n, wr_n, ale_pullup;

    int n_run = 0;
    int n_fail = 0;
    int t = 11;
    int kind_m = 0;
    bit r10_mode = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xbus_strobe_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .ale_off(ale_off),
        .table_op(table_op), .idle(idle), .pdown(pdown), .emul(emul),
        .ext_exec(ext_exec), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .ale_pullup(ale_pullup)
    );

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s tick=%0d kind=%0d actual=%b expected=%b", tag, nm, t, kind_m, act, exp);
        end
    endtask

    function automatic bit exp_gate();
        return ale_off && !(table_op || idle || pdown || emul) && !ext_exec;
    endfunction

    // one clock: inputs already set; check outputs after the edge
    task automatic step();
        bit data, g, e_ale, e_ps, e_rd, e_wr;
        int h;
        string ta, tp, td;
        @(posedge clk);
        t = (t + 1) % 12;
        if (t == 0) kind_m = int'(cyc_kind);
        #1;
        data  = (kind_m == 2) || (kind_m == 3);
        h     = t % 6;
        g     = exp_gate();
        e_ale = (h < 2) && !(t >= 6 && data) && !g;
        e_ps  = !(kind_m == 1 && h >= 2 && h < 5);
        e_rd  = !(kind_m == 2 && t >= 3 && t < 9);
        e_wr  = !(kind_m == 3 && t >= 3 && t < 9);
        if (ale_off && ext_exec) ta = "R9";
        else if (ale_off && (table_op || idle || pdown || emul)) ta = "R8";
        else if (ale_off) ta = "R7";
        else if (data && t >= 6 && h < 2) ta = "R3";
        else ta = "R2";
        tp = r10_mode ? "R10" : (data ? "R5" : "R4");
        td = r10_mode ? "R10" : "R6";
        chk(ta, "ale", ale, e_ale);
        chk(tp, "psen_n", psen_n, e_ps);
        chk(td, "rd_n", rd_n, e_rd);
        chk(td, "wr_n", wr_n, e_wr);
        chk(ale_off ? ta : "R7", "ale_pullup", ale_pullup, g);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            chk("R1", "ale", ale, 1'b0);
            chk("R1", "psen_n", psen_n, 1'b1);
            chk("R1", "rd_n", rd_n, 1'b1);
            chk("R1", "wr_n", wr_n, 1'b1);
            chk("R1", "ale_pullup", ale_pullup, 1'b0);
        end
        rst_n = 1'b1;
        t = 11;
        kind_m = 0;
    endtask

    task automatic run_cycles(input int kind, input int ncyc);
        cyc_kind = 2'(kind);
        for (int i = 0; i < ncyc * 12; i++) step();
    endtask

    task automatic set_modes(input bit d, input bit tb, input bit id, input bit pd, input bit em, input bit ex);
        ale_off = d; table_op = tb; idle = id; pdown = pd; emul = em; ext_exec = ex;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        ale_off = 1'b1;
        do_reset();
        ale_off = 1'b0;
        // directed: each kind, disable clear (R2..R6)
        for (int k = 0; k < 4; k++) run_cycles(k, 3);
        run_cycles(3, 1);
        run_cycles(1, 1);
        run_cycles(2, 1);
        // disable alone (R7), each suspension (R8), external execution (R9)
        set_modes(1, 0, 0, 0, 0, 0); run_cycles(1, 2); run_cycles(2, 1);
        set_modes(1, 1, 0, 0, 0, 0); run_cycles(3, 2);
        set_modes(1, 0, 1, 0, 0, 0); run_cycles(0, 2);
        set_modes(1, 0, 0, 1, 0, 0); run_cycles(1, 2);
        set_modes(1, 0, 0, 0, 1, 0); run_cycles(2, 2);
        set_modes(1, 0, 0, 0, 0, 1); run_cycles(1, 2);
        set_modes(0, 0, 0, 0, 0, 0);
        // R10: kind toggles on every edge, only the start edge counts
        r10_mode = 1;
        for (int i = 0; i < 20 * 12; i++) begin
            cyc_kind = 2'($urandom_range(0, 3));
            step();
        end
        r10_mode = 0;
        // mid-run reset then random mix
        do_reset();
        for (int i = 0; i < 300 * 12; i++) begin
            if (i % 12 == 11) cyc_kind = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 15) == 0) begin
                ale_off  = ($urandom_range(0, 1) == 1);
                table_op = ($urandom_range(0, 5) == 0);
                idle     = ($urandom_range(0, 7) == 0);
                pdown    = ($urandom_range(0, 9) == 0);
                emul     = ($urandom_range(0, 9) == 0);
                ext_exec = ($urandom_range(0, 4) == 0);
            end
            step();
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule